// File: doc/BRIEF.md
# Mantissa Denormalizing Right Shifter

This block moves an extended-precision floating-point operand to a larger exponent. It shifts the 64-bit mantissa right by an unsigned 8-bit count and adds that count to the 15-bit biased exponent. An 8-bit guard byte sits below the mantissa. The block fills it with the bits that leave the bottom of the mantissa, and every bit that falls further down is folded into a sticky flag in the guard byte's lowest bit. The guard byte that comes in is thrown away.

How the guard byte is formed depends on the count. Small counts lose no bits, so the guard byte is an exact copy of what was shifted out. Medium counts keep the eight bits just below the new binary point and OR everything lower into bit 0. Counts at or beyond the width of mantissa plus guard leave only a single sticky bit that records whether the mantissa was nonzero. The result is registered once and is qualified by a valid strobe. Rounding, exception reporting and renormalization are done by the blocks downstream.

Top module: `mant_denorm_shifter`

## Requirements
- R1: The result exponent is the input exponent plus the zero-extended shift count, taken modulo 2^15. For example, 0x7FFF shifted by 2 gives 0x0001.
- R2: For counts 0 to 8, the guard byte holds exactly the mantissa bits shifted out. The last bit to leave sits in guard bit 7, the lower guard bits are zero, and no sticky OR is applied. A count of 0 gives a guard byte of 0x00.
- R3: For counts 9 to 71, the guard byte bits 7..0 are mantissa input bits count-1 down to count-8. Guard bit 0 is additionally ORed with every mantissa input bit from count-9 down to 0.
- R4: For counts below 72, the result mantissa equals the input mantissa logically shifted right by the count.
- R5: For counts of 72 and above (up to 255), the result mantissa is zero. The guard byte is 0x01 when the input mantissa was nonzero and 0x00 otherwise.
- R6: For counts 32 to 71, result mantissa bits 63..32 are zero.
- R7: The incoming guard byte has no effect on any output.
- R8: A result appears on the outputs, with out_valid high, on the clock edge after the one that samples in_valid high. out_valid is low after any cycle in which in_valid was low.
- R9: A synchronous active-high reset clears out_valid on the next rising clock edge, even if in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operand and the count |
| in_mant | input | 64 | Input mantissa |
| in_guard | input | 8 | Input guard byte, ignored |
| in_exp | input | 15 | Input biased exponent |
| in_count | input | 8 | Unsigned right-shift count |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_mant | output | 64 | Shifted mantissa |
| out_guard | output | 8 | Guard byte with sticky bit 0 |
| out_exp | output | 15 | Exponent plus count |

## Verification
The hardest cases to reach from the ports are those where the sticky bit alone decides guard bit 0. In these cases a single set bit lies exactly one position below the eight kept guard bits, or exactly at the boundary between the exact range and the sticky range. Random mantissas almost always have set bits both above and below any boundary, so they hide these cases. The stimulus therefore walks every count from 0 to 80. At each count it applies a single set bit at every one of several chosen positions, together with all-zero, all-ones and random words. A short table of hand-worked vectors also pins the count boundaries 8/9, 71/72 and the exponent wrap.

// File: rtl/mant_denorm_pkg.sv
package mant_denorm_pkg;

  // Default geometry of the extended-precision operand.
  localparam int DN_MANT_W  = 64;
  localparam int DN_GUARD_W = 8;
  localparam int DN_EXP_W   = 15;
  localparam int DN_CNT_W   = 8;

  // Which rule forms the guard byte for a given shift count.
  typedef enum logic [1:0] {
    RNG_EXACT    = 2'd0,  // no bits lost below the guard byte
    RNG_STICKY   = 2'd1,  // lost bits fold into guard bit 0
    RNG_COLLAPSE = 2'd2   // whole mantissa collapses into sticky
  } shift_range_e;

endpackage

// File: rtl/dn_classify.sv
module dn_classify
  import mant_denorm_pkg::*;
#(
  parameter int CNT_W   = DN_CNT_W,
  parameter int MANT_W  = DN_MANT_W,
  parameter int GUARD_W = DN_GUARD_W
) (
  input  logic [CNT_W-1:0] cnt,
  output shift_range_e     rng
);
  localparam int LIMIT = MANT_W + GUARD_W;

  function automatic shift_range_e classify(input logic [CNT_W-1:0] c);
    if (int'(c) <= GUARD_W)    return RNG_EXACT;
    else if (int'(c) < LIMIT)  return RNG_STICKY;
    else                       return RNG_COLLAPSE;
  endfunction

  assign rng = classify(cnt);
endmodule

// File: rtl/dn_sticky.sv
module dn_sticky #(
  parameter int CNT_W   = 8,
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [CNT_W-1:0]  cnt,
  output logic              sticky_hit,
  output logic              mant_nz
);
  localparam int LIMIT = MANT_W + GUARD_W;

  // A mantissa bit i is lost below the guard byte when cnt > i + GUARD_W.
  logic [MANT_W-1:0] lost_mask;

  for (genvar i = 0; i < MANT_W; i++) begin : g_mask
    assign lost_mask[i] = (int'(cnt) > i + GUARD_W);
  end

  assign sticky_hit = |(mant & lost_mask);
  assign mant_nz    = |mant;

  // R5: at collapse counts every mantissa bit is lost, so sticky equals nonzero
  always_comb begin
    if (int'(cnt) >= LIMIT) begin
      a_r5_collapse_sticky: assert (sticky_hit == mant_nz);
    end
  end
endmodule

// File: rtl/dn_align.sv
module dn_align
  import mant_denorm_pkg::*;
#(
  parameter int CNT_W   = DN_CNT_W,
  parameter int MANT_W  = DN_MANT_W,
  parameter int GUARD_W = DN_GUARD_W
) (
  input  logic [MANT_W-1:0]  mant,
  input  logic [CNT_W-1:0]   cnt,
  input  shift_range_e       rng,
  input  logic               sticky_hit,
  input  logic               mant_nz,
  output logic [MANT_W-1:0]  mant_o,
  output logic [GUARD_W-1:0] guard_o
);
  localparam int EXT_W = MANT_W + GUARD_W;

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] shifted;

  function automatic logic [EXT_W-1:0] shift_ext(input logic [EXT_W-1:0] v,
                                                 input logic [CNT_W-1:0] c);
    return v >> c;
  endfunction

  assign ext     = {mant, {GUARD_W{1'b0}}};
  assign shifted = shift_ext(ext, cnt);

  always_comb begin
    unique case (rng)
      RNG_COLLAPSE: begin
        mant_o  = '0;
        guard_o = {{(GUARD_W-1){1'b0}}, mant_nz};
      end
      RNG_STICKY: begin
        mant_o  = shifted[EXT_W-1:GUARD_W];
        guard_o = shifted[GUARD_W-1:0] | {{(GUARD_W-1){1'b0}}, sticky_hit};
      end
      default: begin
        mant_o  = shifted[EXT_W-1:GUARD_W];
        guard_o = shifted[GUARD_W-1:0];
      end
    endcase
  end

  // R2: small counts never lose bits below the guard byte
  always_comb begin
    if (rng == RNG_EXACT) begin
      a_r2_no_sticky_loss: assert (!sticky_hit);
    end
  end
endmodule

// File: rtl/dn_expo.sv
module dn_expo #(
  parameter int EXP_W = 15,
  parameter int CNT_W = 8
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [CNT_W-1:0] cnt,
  output logic [EXP_W-1:0] exp_o
);
  function automatic logic [EXP_W-1:0] bump(input logic [EXP_W-1:0] e,
                                            input logic [CNT_W-1:0] c);
    return e + EXP_W'(c);
  endfunction

  assign exp_o = bump(exp_i, cnt);
endmodule

// File: rtl/mant_denorm_shifter.sv
module mant_denorm_shifter
  import mant_denorm_pkg::*;
#(
  parameter int MANT_W  = DN_MANT_W,
  parameter int GUARD_W = DN_GUARD_W,
  parameter int EXP_W   = DN_EXP_W,
  parameter int CNT_W   = DN_CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MANT_W-1:0]  in_mant,
  input  logic [GUARD_W-1:0] in_guard,
  input  logic [EXP_W-1:0]   in_exp,
  input  logic [CNT_W-1:0]   in_count,
  output logic               out_valid,
  output logic [MANT_W-1:0]  out_mant,
  output logic [GUARD_W-1:0] out_guard,
  output logic [EXP_W-1:0]   out_exp
);
  localparam int LIMIT = MANT_W + GUARD_W;
  localparam int HALF  = MANT_W / 2;

  shift_range_e       rng;
  logic               sticky_hit;
  logic               mant_nz;
  logic [MANT_W-1:0]  mant_nx;
  logic [GUARD_W-1:0] guard_nx;
  logic [EXP_W-1:0]   exp_nx;
  logic               guard_unused;

  // The incoming guard byte is discarded by definition.
  assign guard_unused = ^in_guard;

  dn_classify #(.CNT_W(CNT_W), .MANT_W(MANT_W), .GUARD_W(GUARD_W)) u_class (
    .cnt (in_count),
    .rng (rng)
  );

  dn_sticky #(.CNT_W(CNT_W), .MANT_W(MANT_W), .GUARD_W(GUARD_W)) u_sticky (
    .mant       (in_mant),
    .cnt        (in_count),
    .sticky_hit (sticky_hit),
    .mant_nz    (mant_nz)
  );

  dn_align #(.CNT_W(CNT_W), .MANT_W(MANT_W), .GUARD_W(GUARD_W)) u_align (
    .mant       (in_mant),
    .cnt        (in_count),
    .rng        (rng),
    .sticky_hit (sticky_hit),
    .mant_nz    (mant_nz),
    .mant_o     (mant_nx),
    .guard_o    (guard_nx)
  );

  dn_expo #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_expo (
    .exp_i (in_exp),
    .cnt   (in_count),
    .exp_o (exp_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mant  <= '0;
      out_guard <= '0;
      out_exp   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mant  <= mant_nx;
        out_guard <= guard_nx;
        out_exp   <= exp_nx;
      end
    end
  end

  // R1: exponent grows by the count
  a_r1_exp_sum: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_exp == EXP_W'($past(in_exp) + EXP_W'($past(in_count))));

  // R5: large counts clear the mantissa and leave one sticky bit
  a_r5_collapse: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int'($past(in_count)) >= LIMIT) |->
      (out_mant == '0 && out_guard == {{(GUARD_W-1){1'b0}}, |$past(in_mant)}));

  // R6: upper half empty for mid-range counts
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int'($past(in_count)) >= HALF && int'($past(in_count)) < LIMIT)
      |-> out_mant[MANT_W-1:HALF] == '0);

  // R8: a result only follows a sampled valid input
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/mant_denorm_shifter_tb.sv
`timescale 1ns/1ps
module mant_denorm_shifter_tb;
  localparam int MW = 64;
  localparam int GW = 8;
  localparam int EW = 15;
  localparam int CW = 8;
  localparam int VW = MW + GW + EW + CW + MW + GW + EW;
  localparam int NV = 9;

  // {mant, guard_in, exp, count, exp_mant, exp_guard, exp_exp}
  localparam logic [NV-1:0][VW-1:0] VECS = '{
    {64'h8000_0000_0000_0001, 8'h00, 15'h3FFF, 8'd1,
     64'h4000_0000_0000_0000, 8'h80, 15'h4000},                 // R2
    {64'h8000_0000_0000_0001, 8'h00, 15'h3FFF, 8'd9,
     64'h0040_0000_0000_0000, 8'h01, 15'h4008},                 // R3 sticky only
    {64'hFFFF_FFFF_FFFF_FFFF, 8'h5A, 15'h0100, 8'd72,
     64'h0, 8'h01, 15'h0148},                                   // R5
    {64'h0, 8'hFF, 15'h0010, 8'd200,
     64'h0, 8'h00, 15'h00D8},                                   // R5 zero
    {64'h0000_0000_0000_FF00, 8'h00, 15'h0000, 8'd16,
     64'h0, 8'hFF, 15'h0010},                                   // R3
    {64'h8000_0000_0000_0000, 8'h00, 15'h1000, 8'd71,
     64'h0, 8'h01, 15'h1047},                                   // R3 edge
    {64'h8000_0000_0000_0000, 8'h00, 15'h1000, 8'd64,
     64'h0, 8'h80, 15'h1040},                                   // R6
    {64'h0000_0000_0000_0003, 8'h00, 15'h7FFF, 8'd2,
     64'h0, 8'hC0, 15'h0001},                                   // R1 wrap
    {64'h1234_5678_9ABC_DEF0, 8'hAA, 15'h2222, 8'd0,
     64'h1234_5678_9ABC_DEF0, 8'h00, 15'h2222}                  // R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [MW-1:0] in_mant = '0;
  logic [GW-1:0] in_guard = '0;
  logic [EW-1:0] in_exp = '0;
  logic [CW-1:0] in_count = '0;
  logic          out_valid;
  logic [MW-1:0] out_mant;
  logic [GW-1:0] out_guard;
  logic [EW-1:0] out_exp;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mant_denorm_shifter u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mant(in_mant),
    .in_guard(in_guard), .in_exp(in_exp), .in_count(in_count),
    .out_valid(out_valid), .out_mant(out_mant), .out_guard(out_guard),
    .out_exp(out_exp)
  );

  task automatic check(input string req, input logic [MW-1:0] act,
                       input logic [MW-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // Independent model: place each mantissa bit by its final position.
  task automatic model(input logic [MW-1:0] m, input logic [EW-1:0] e,
                       input int c, output logic [MW-1:0] mo,
                       output logic [GW-1:0] go, output logic [EW-1:0] eo);
    bit stk = 0;
    mo = '0; go = '0;
    for (int i = 0; i < MW; i++) begin
      int pos = i + GW - c;
      if (m[i]) begin
        if (pos >= GW) mo[pos-GW] = 1'b1;
        else if (pos >= 0) go[pos] = 1'b1;
        else stk = 1;
      end
    end
    if (stk) go[0] = 1'b1;
    eo = EW'(int'(e) + c);
  endtask

  task automatic apply(input logic [MW-1:0] m, input logic [GW-1:0] g,
                       input logic [EW-1:0] e, input logic [CW-1:0] c,
                       input logic [MW-1:0] em, input logic [GW-1:0] eg,
                       input logic [EW-1:0] ee, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_mant = m; in_guard = g; in_exp = e; in_count = c;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 valid"}, MW'(out_valid), MW'(1));
    check({tag, " mant R4"}, out_mant, em);
    check({tag, " guard R2/R3/R5"}, MW'(out_guard), MW'(eg));
    check({tag, " exp R1"}, MW'(out_exp), MW'(ee));
  endtask

  task automatic run_model(input logic [MW-1:0] m, input int c);
    logic [MW-1:0] mo; logic [GW-1:0] go; logic [EW-1:0] eo;
    logic [EW-1:0] e = EW'($urandom);
    model(m, e, c, mo, go, eo);
    apply(m, GW'($urandom), e, CW'(c), mo, go, eo, "sweep");
    if (c >= 32 && c < 72) check("R6 upper", MW'(out_mant[MW-1:32]), '0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", MW'(out_valid), MW'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle out_valid", MW'(out_valid), MW'(0));

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v = VECS[k];
      apply(v[VW-1 -: MW], v[VW-MW-1 -: GW], v[VW-MW-GW-1 -: EW],
            v[VW-MW-GW-EW-1 -: CW], v[MW+GW+EW-1 -: MW],
            v[GW+EW-1 -: GW], v[EW-1:0], "table");
    end

    // R7: same operand with two guard inputs must give identical guard out
    apply(64'hF0F0_0000_0000_0000, 8'hFF, 15'h0, 8'd4,
          64'h0F0F_0000_0000_0000, 8'h00, 15'h4, "R7 ones");

    for (int c = 0; c <= 80; c++) begin
      run_model('0, c);
      run_model('1, c);
      run_model({$urandom, $urandom}, c);
      for (int b = 0; b < MW; b += 9) run_model(MW'(1) << b, c);
      if (c >= 9 && c < 72) run_model(MW'(1) << (c - 9), c);  // R3 lone sticky bit
      if (c >= 9 && c < 72) run_model(MW'(1) << (c - 8), c);  // R3 lowest kept bit
    end

    @(negedge clk);
    check("R8 drop after idle", MW'(out_valid), MW'(0));

    // R9: reset wins over a valid input
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R9 reset over valid", MW'(out_valid), MW'(0));
    in_valid = 1'b0; rst = 1'b0;
    finish_up();
  end
endmodule